// File: doc/BRIEF.md
# Shared Parameter RAM Slot Arbiter

This block shares one single-port parameter RAM among three requesters: a host processor port, a coherent data-transfer port that moves parameter pairs, and a processing engine. Each clock cycle is one access slot. In each slot at most one requester is granted, and its address, write enable and write data go to the RAM. The data of a granted read appears on a shared read-data output in the following slot.

Priority is not fixed. It depends on a one-slot history register that records whether the host or the transfer port moved data in the previous slot. It also depends on flags from the engine. One flag marks an access as the second half of a back-to-back pair, and that half is always granted, so the pair cannot be split by the host or the transfer port. A second flag marks the first preload of a new thread. That access always counts as a first access, even if the pair flag is still high from the end of the previous thread. A requester that loses keeps its request high and is served in a later slot.

Top module: `spram_arb`

## Requirements
- R1: In every slot at most one of `hst_gnt`, `xfr_gnt`, `eng_gnt` is high, and a grant goes only to a port whose request is high. After reset, with no requests, all grants are low.
- R2: If the host or the transfer port was granted in the previous slot, a requesting engine wins the current slot, unless `hst_other_pend` is high.
- R3: An engine request with `eng_pair`=1 and `eng_tstart`=0 is the second access of a back-to-back pair. It is granted in its slot whatever the host and transfer port request.
- R4: If the engine was granted or no one was granted in the previous slot, and the engine is not finishing a pair, the host and transfer side beats the engine. Within that side, a transfer request with `xfr_mid`=1 beats the host, and otherwise the host beats the transfer port.
- R5: An engine access with `eng_tstart`=1 counts as a first access even when `eng_pair`=1, so it does not get pair priority.
- R6: The preloads at thread start form an atomic run: the first preload has `eng_tstart`=1, the following ones have `eng_pair`=1 and `eng_tstart`=0, and once the first preload is granted every following preload is granted back-to-back, ahead of a requesting host.
- R7: The write enables `hst_we`, `xfr_we` and `eng_we` have no effect on which port is granted.
- R8: A granted engine read counts as a RAM use for the history even if its data is thrown away, so the host wins the next contested slot.
- R9: Reset clears the history, so the host wins the first slot in which it contends with the engine.
- R10: If no request is high, no grant is high. If any request is high, exactly one grant is high. A losing requester that keeps its request high is granted in a later slot, and its write does not reach the RAM in the slot it lost.
- R11: A granted write stores its data at its address. A granted read returns the stored word at its address on `rdata` in the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one access slot |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_req | input | 1 | Host access request |
| hst_we | input | 1 | Host write enable |
| hst_addr | input | AW | Host word address |
| hst_wdata | input | DW | Host write data |
| hst_other_pend | input | 1 | Host has an access waiting on the other engine |
| hst_gnt | output | 1 | Host granted this slot |
| xfr_req | input | 1 | Transfer port access request |
| xfr_we | input | 1 | Transfer port write enable |
| xfr_addr | input | AW | Transfer port word address |
| xfr_wdata | input | DW | Transfer port write data |
| xfr_mid | input | 1 | Transfer port is past the first read of a pair transfer |
| xfr_gnt | output | 1 | Transfer port granted this slot |
| eng_req | input | 1 | Engine access request |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | AW | Engine word address |
| eng_wdata | input | DW | Engine write data |
| eng_pair | input | 1 | Access is the second of a back-to-back pair |
| eng_tstart | input | 1 | Access is the first preload of a thread |
| eng_gnt | output | 1 | Engine granted this slot |
| rdata | output | DW | Read data of the read granted in the previous slot |

## Verification
The bench goes after the priority turns that depend on the history. These are the slot right after reset, the slot after a host or transfer access, and the slot after an engine or idle slot. A design that does not update or clear the history would grant the same port twice in a row, or would give the engine the first contested slot. The bench checks that `eng_tstart` overrides a stale pair flag, and that a run of preloads is not split. A design that gets this wrong would either let the host break into the run or give a new thread pair priority. Further sequences change only the write enables, or hold a losing write, and then read the RAM back. A design whose decision depends on direction, or that commits a losing write, would show a wrong grant or a wrong stored word.

// File: rtl/spram_arb_pkg.sv
package spram_arb_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'd0,
      OWN_HST  = 2'd1,
      OWN_XFR  = 2'd2,
      OWN_ENG  = 2'd3
   } owner_e;
endpackage

// File: rtl/spram_arb_pick.sv
module spram_arb_pick
   import spram_arb_pkg::*;
(
   input  logic   hst_req,
   input  logic   hst_other_pend,
   input  logic   xfr_req,
   input  logic   xfr_mid,
   input  logic   eng_req,
   input  logic   eng_pair,
   input  logic   eng_tstart,
   input  logic   prev_side,
   output owner_e owner
);
   logic eng_b2b;
   logic eng_hist;
   logic eng_first;

   always_comb begin
      eng_b2b   = eng_req & eng_pair & ~eng_tstart;
      eng_hist  = eng_req & prev_side & ~hst_other_pend;
      eng_first = eng_b2b | eng_hist;
      if (eng_first)                owner = OWN_ENG;
      else if (xfr_req && xfr_mid)  owner = OWN_XFR;
      else if (hst_req)             owner = OWN_HST;
      else if (xfr_req)             owner = OWN_XFR;
      else if (eng_req)             owner = OWN_ENG;
      else                          owner = OWN_NONE;
   end
endmodule

// File: rtl/spram_arb_hist.sv
module spram_arb_hist
   import spram_arb_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  owner_e owner,
   output logic   prev_side
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_side <= 1'b0;
      else        prev_side <= (owner == OWN_HST) || (owner == OWN_XFR);
   end
endmodule

// File: rtl/spram_arb_ram.sv
module spram_arb_ram #(
   parameter int AW        = 6,
   parameter int DW        = 24,
   parameter bit WRITE_THRU = 1'b0
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en && we) mem[addr] <= wdata;
   end

   generate
      if (WRITE_THRU) begin : g_thru
         always_ff @(posedge clk) begin
            if (en) rdata <= we ? wdata : mem[addr];
         end
      end else begin : g_old
         always_ff @(posedge clk) begin
            if (en) rdata <= mem[addr];
         end
      end
   endgenerate
endmodule

// File: rtl/spram_arb.sv
module spram_arb
   import spram_arb_pkg::*;
#(
   parameter int AW         = 6,
   parameter int DW         = 24,
   parameter bit WRITE_THRU = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hst_req,
   input  logic          hst_we,
   input  logic [AW-1:0] hst_addr,
   input  logic [DW-1:0] hst_wdata,
   input  logic          hst_other_pend,
   output logic          hst_gnt,
   input  logic          xfr_req,
   input  logic          xfr_we,
   input  logic [AW-1:0] xfr_addr,
   input  logic [DW-1:0] xfr_wdata,
   input  logic          xfr_mid,
   output logic          xfr_gnt,
   input  logic          eng_req,
   input  logic          eng_we,
   input  logic [AW-1:0] eng_addr,
   input  logic [DW-1:0] eng_wdata,
   input  logic          eng_pair,
   input  logic          eng_tstart,
   output logic          eng_gnt,
   output logic [DW-1:0] rdata
);
   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("spram_arb: AW out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("spram_arb: DW must be positive");
      end
   endgenerate

   owner_e        owner;
   logic          prev_side;
   logic          ram_en;
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;

   spram_arb_pick u_pick (
      .hst_req        (hst_req),
      .hst_other_pend (hst_other_pend),
      .xfr_req        (xfr_req),
      .xfr_mid        (xfr_mid),
      .eng_req        (eng_req),
      .eng_pair       (eng_pair),
      .eng_tstart     (eng_tstart),
      .prev_side      (prev_side),
      .owner          (owner)
   );

   spram_arb_hist u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .owner     (owner),
      .prev_side (prev_side)
   );

   assign hst_gnt = (owner == OWN_HST);
   assign xfr_gnt = (owner == OWN_XFR);
   assign eng_gnt = (owner == OWN_ENG);

   always_comb begin
      ram_en = (owner != OWN_NONE);
      unique case (owner)
         OWN_HST: begin ram_we = hst_we; ram_addr = hst_addr; ram_wdata = hst_wdata; end
         OWN_XFR: begin ram_we = xfr_we; ram_addr = xfr_addr; ram_wdata = xfr_wdata; end
         OWN_ENG: begin ram_we = eng_we; ram_addr = eng_addr; ram_wdata = eng_wdata; end
         default: begin ram_we = 1'b0;   ram_addr = '0;       ram_wdata = '0;        end
      endcase
   end

   spram_arb_ram #(.AW(AW), .DW(DW), .WRITE_THRU(WRITE_THRU)) u_ram (
      .clk   (clk),
      .en    (ram_en),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (rdata)
   );

   // R1
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hst_gnt, xfr_gnt, eng_gnt}));
   // R1
   gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hst_gnt || hst_req) && (!xfr_gnt || xfr_req) && (!eng_gnt || eng_req));
   // R10
   work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_req || xfr_req || eng_req) |-> (hst_gnt || xfr_gnt || eng_gnt));
   // R3
   pair_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && eng_pair && !eng_tstart) |-> eng_gnt);
   // R2
   eng_after_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_gnt || xfr_gnt) ##1 (eng_req && !hst_other_pend) |-> eng_gnt);
   // R4
   host_after_eng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_gnt ##1 (hst_req && !xfr_req && !(eng_req && eng_pair && !eng_tstart)) |-> hst_gnt);
endmodule

// File: tb/spram_arb_tb_top.sv
module spram_arb_tb_top;
   localparam int AW = 6;
   localparam int DW = 24;

   typedef struct {
      logic          hr, hw, hp;
      logic [AW-1:0] ha;
      logic [DW-1:0] hd;
      logic          xr, xw, xm;
      logic [AW-1:0] xa;
      logic [DW-1:0] xd;
      logic          er, ew, ep, et;
      logic [AW-1:0] ea;
      logic [DW-1:0] ed;
   } stim_t;

   typedef struct {
      logic [2:0]    gnt;
      logic          rchk;
      logic [DW-1:0] rexp;
      string         tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic          hst_req = 0, hst_we = 0, hst_other_pend = 0, hst_gnt;
   logic [AW-1:0] hst_addr = '0;
   logic [DW-1:0] hst_wdata = '0;
   logic          xfr_req = 0, xfr_we = 0, xfr_mid = 0, xfr_gnt;
   logic [AW-1:0] xfr_addr = '0;
   logic [DW-1:0] xfr_wdata = '0;
   logic          eng_req = 0, eng_we = 0, eng_pair = 0, eng_tstart = 0, eng_gnt;
   logic [AW-1:0] eng_addr = '0;
   logic [DW-1:0] eng_wdata = '0;
   logic [DW-1:0] rdata;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   exp_t q[$];

   always #2 clk = ~clk;

   spram_arb #(.AW(AW), .DW(DW)) dut_i (
      .clk, .rst_n,
      .hst_req, .hst_we, .hst_addr, .hst_wdata, .hst_other_pend, .hst_gnt,
      .xfr_req, .xfr_we, .xfr_addr, .xfr_wdata, .xfr_mid, .xfr_gnt,
      .eng_req, .eng_we, .eng_addr, .eng_wdata, .eng_pair, .eng_tstart, .eng_gnt,
      .rdata
   );

   function automatic stim_t idle_s();
      stim_t s;
      s.hr = 0; s.hw = 0; s.hp = 0; s.ha = '0; s.hd = '0;
      s.xr = 0; s.xw = 0; s.xm = 0; s.xa = '0; s.xd = '0;
      s.er = 0; s.ew = 0; s.ep = 0; s.et = 0; s.ea = '0; s.ed = '0;
      return s;
   endfunction

   // driver: applies one slot of stimulus and pushes the expected result
   task automatic slot(input stim_t s, input logic [2:0] gnt, input logic rchk,
                       input logic [DW-1:0] rexp, input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      hst_req = s.hr; hst_we = s.hw; hst_other_pend = s.hp; hst_addr = s.ha; hst_wdata = s.hd;
      xfr_req = s.xr; xfr_we = s.xw; xfr_mid = s.xm; xfr_addr = s.xa; xfr_wdata = s.xd;
      eng_req = s.er; eng_we = s.ew; eng_pair = s.ep; eng_tstart = s.et;
      eng_addr = s.ea; eng_wdata = s.ed;
      e.gnt = gnt; e.rchk = rchk; e.rexp = rexp; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: grant vector is {eng, xfr, hst}
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         logic [2:0] g;
         e = q.pop_front();
         g = {eng_gnt, xfr_gnt, hst_gnt};
         total++;
         if (g !== e.gnt) begin
            bad++;
            $display("FAIL %s grant actual=%b expected=%b", e.tag, g, e.gnt);
         end
         if (e.rchk) begin
            total++;
            if (rdata !== e.rexp) begin
               bad++;
               $display("FAIL %s rdata actual=%h expected=%h", e.tag, rdata, e.rexp);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      stim_t s;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state: no request, no grant
      slot(idle_s(), 3'b000, 0, '0, "R1_reset");
      // R9: first contest after reset goes to host
      s = idle_s(); s.hr = 1; s.er = 1;
      slot(s, 3'b001, 0, '0, "R9_first");
      // R2: host moved data last slot -> engine
      slot(s, 3'b100, 0, '0, "R2_after_host");
      // R4: engine used RAM last slot -> host
      slot(s, 3'b001, 0, '0, "R4_after_eng");
      // R2 other-engine pending blocks engine priority
      slot(idle_s(), 3'b000, 0, '0, "R1_idle");
      s = idle_s(); s.hr = 1;
      slot(s, 3'b001, 0, '0, "R10_host_alone");
      s.er = 1; s.hp = 1;
      slot(s, 3'b001, 0, '0, "R2_other_pend");
      // R3: pair second access beats host
      s = idle_s(); s.hr = 1; s.er = 1;
      slot(s, 3'b100, 0, '0, "R2_eng_turn");
      s.ep = 1;
      slot(s, 3'b100, 0, '0, "R3_pair");
      // R5: thread start overrides stale pair flag
      s.ep = 1; s.et = 1;
      slot(s, 3'b001, 0, '0, "R5_tstart");
      // R6: preload run stays atomic
      slot(idle_s(), 3'b000, 0, '0, "R1_idle2");
      s = idle_s(); s.hr = 1; s.er = 1; s.et = 1;
      slot(s, 3'b001, 0, '0, "R6_first_loses");
      slot(s, 3'b100, 0, '0, "R6_first_wins");
      s.et = 0; s.ep = 1;
      slot(s, 3'b100, 0, '0, "R6_preload2");
      slot(s, 3'b100, 0, '0, "R6_preload3");
      s = idle_s(); s.hr = 1;
      slot(s, 3'b001, 0, '0, "R6_host_after");
      // R4 transfer port ordering
      slot(idle_s(), 3'b000, 0, '0, "R1_idle3");
      s = idle_s(); s.er = 1;
      slot(s, 3'b100, 0, '0, "R10_eng_alone");
      s.hr = 1; s.xr = 1; s.xm = 1;
      slot(s, 3'b010, 0, '0, "R4_xfr_mid");
      s = idle_s(); s.hr = 1; s.er = 1;
      slot(s, 3'b100, 0, '0, "R2_after_xfr");
      s = idle_s(); s.hr = 1; s.xr = 1;
      slot(s, 3'b001, 0, '0, "R4_host_over_xfr");
      slot(s, 3'b001, 0, '0, "R4_host_again");
      s = idle_s(); s.xr = 1;
      slot(s, 3'b010, 0, '0, "R10_xfr_later");
      // R7: write enables do not change the decision
      slot(idle_s(), 3'b000, 0, '0, "R1_idle4");
      s = idle_s(); s.hr = 1; s.hw = 1; s.ha = 6'd40; s.er = 1; s.ew = 0;
      slot(s, 3'b001, 0, '0, "R7_host_write");
      s.hw = 0; s.ew = 1; s.ea = 6'd41;
      slot(s, 3'b100, 0, '0, "R7_eng_write");
      // R8: discarded engine read still counts
      s = idle_s(); s.er = 1;
      slot(s, 3'b100, 0, '0, "R8_dummy_read");
      s.hr = 1;
      slot(s, 3'b001, 0, '0, "R8_host_next");
      // R11 RAM traffic
      slot(idle_s(), 3'b000, 0, '0, "R1_idle5");
      s = idle_s(); s.hr = 1; s.hw = 1; s.ha = 6'd5; s.hd = 24'hABCDE;
      slot(s, 3'b001, 0, '0, "R11_hwrite");
      s = idle_s(); s.er = 1; s.ew = 1; s.ea = 6'd9; s.ed = 24'h123456;
      slot(s, 3'b100, 0, '0, "R11_ewrite");
      s = idle_s(); s.xr = 1; s.xa = 6'd5;
      slot(s, 3'b010, 0, '0, "R11_xread");
      s = idle_s(); s.er = 1; s.ea = 6'd9;
      slot(s, 3'b100, 1, 24'hABCDE, "R11_xread_data");
      slot(idle_s(), 3'b000, 1, 24'h123456, "R11_eread_data");
      // R10: losing write is not committed, host served later
      s = idle_s(); s.hr = 1; s.hw = 1; s.ha = 6'd3; s.hd = 24'h000011;
      slot(s, 3'b001, 0, '0, "R10_seed");
      s.hd = 24'h000022; s.er = 1; s.ea = 6'd3;
      slot(s, 3'b100, 0, '0, "R10_host_loses");
      s.er = 0;
      slot(s, 3'b001, 1, 24'h000011, "R10_no_commit");
      s = idle_s(); s.er = 1; s.ea = 6'd3;
      slot(s, 3'b100, 0, '0, "R10_eng_reads");
      slot(idle_s(), 3'b000, 1, 24'h000022, "R10_late_write");
      repeat (3) @(posedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule